// File: doc/BRIEF.md
# FIFO Threshold Offset Register Unit

This block keeps the two offsets that set where a FIFO's almost-empty and almost-full flags trip. It sends both to the flag comparators. A single strap input, `ld`, is sampled while master reset is held. That one level picks both the default offset pair and the way the offsets may be reprogrammed afterwards: one bit at a time from a serial input, or in 9-bit pieces from the data bus. Whichever way the offsets were loaded, software can read them back in pieces on the output bus.

Each offset is 15 bits wide. In parallel form, one full programming pass takes four transfers:

- almost-empty low 9 bits
- almost-empty high 6 bits
- almost-full low 9 bits
- almost-full high 6 bits

In serial form, one pass takes 30 bits, least significant bit first, with the almost-empty offset before the almost-full offset. Partial reset restarts any transfer in progress. It keeps the offsets and the programming method. Master reset restores everything.

Top module: `fifo_ofs_regs`

## Requirements
- R1: On a clock edge with `mrst_n` low, `ld`=1 loads both offsets with 1023 and selects parallel programming (`ser_mode`=0). `ld`=0 loads both offsets with 127 and selects serial programming (`ser_mode`=1). Master reset also clears `dout` to 0.
- R2: In parallel mode, each edge with `ld`, `wen` and both resets high stores `din` into the piece selected by a write index. The pieces are, in order: index 0 is `ae_ofs[8:0]`, 1 is `ae_ofs[14:9]` taken from `din[5:0]`, 2 is `af_ofs[8:0]`, and 3 is `af_ofs[14:9]` taken from `din[5:0]`.
- R3: The parallel write index advances by one per write and returns to 0 after index 3.
- R4: In serial mode, each edge with `ld` and `sen` high stores `sin` into one offset bit. The count starts at `ae_ofs[0]`, rises to `ae_ofs[14]`, then continues through `af_ofs[0]` to `af_ofs[14]`. After 30 bits it starts again at `ae_ofs[0]`.
- R5: Each edge with `ld` and `ren` high places on `dout` the piece chosen by a read index that is separate from the write index. The pieces follow the R2 order, and the 6-bit pieces are zero-padded in `dout[8:6]`. The read index returns to 0 after index 3, and readback works in both modes. At all other times `dout` holds its value.
- R6: Transfers with `ld` low change nothing. `wen` in serial mode changes no offset. `sen` in parallel mode changes no offset.
- R7: A cycle with `prst_n` low and `mrst_n` high leaves both offsets and `ser_mode` unchanged. It returns the write index, read index and serial bit count to their start positions.
- R8: Master reset returns the write index, read index and serial bit count to their start positions.
- R9: `ser_mode` changes only at master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| ld | input | 1 | Offset access select; strap level during master reset |
| wen | input | 1 | Parallel write strobe |
| ren | input | 1 | Parallel read strobe |
| sen | input | 1 | Serial bit strobe |
| sin | input | 1 | Serial data bit |
| din | input | 9 | Parallel write data |
| dout | output | 9 | Parallel readback data |
| ae_ofs | output | 15 | Almost-empty offset to flag logic |
| af_ofs | output | 15 | Almost-full offset to flag logic |
| ser_mode | output | 1 | 1 when serial programming was selected |

## Verification
The bench writes distinct bit patterns into each piece and reads them back. A design that swapped piece order, dropped the zero-padding, or shared one index between reads and writes would show a wrong `dout` value. Index wrap-around is tested with a fifth write and a fifth read; a design that failed to wrap would corrupt a neighbouring piece.

The cross-mode strobes are checked as well: `wen` in serial mode, `sen` in parallel mode, and either strobe with `ld` low. A design that ignored the mode would overwrite offsets. A master reset partway through a serial load is also tested; a design that kept its bit counter would then shift every later bit into the wrong place.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic {
        PROG_PAR = 1'b0,
        PROG_SER = 1'b1
    } prog_mode_e;

    // Number of parallel pieces in one programming pass.
    localparam int unsigned NUM_PIECES = 4;
    localparam int unsigned PIECE_IDX_W = 2;

    function automatic logic [PIECE_IDX_W-1:0] piece_next(input logic [PIECE_IDX_W-1:0] idx);
        return (idx == PIECE_IDX_W'(NUM_PIECES - 1)) ? '0 : idx + 1'b1;
    endfunction

endpackage

// File: rtl/ofs_par_wr.sv
module ofs_par_wr
    import ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned OFS_W  = 15
) (
    input  logic                   en,
    input  logic [PIECE_IDX_W-1:0] idx,
    input  logic [DATA_W-1:0]      din,
    input  logic [OFS_W-1:0]       ae_cur,
    input  logic [OFS_W-1:0]       af_cur,
    output logic [OFS_W-1:0]       ae_nxt,
    output logic [OFS_W-1:0]       af_nxt
);
    localparam int unsigned HI_W = OFS_W - DATA_W;

    always_comb begin
        ae_nxt = ae_cur;
        af_nxt = af_cur;
        if (en) begin
            case (idx)
                2'd0:    ae_nxt[DATA_W-1:0]     = din;
                2'd1:    ae_nxt[OFS_W-1:DATA_W] = din[HI_W-1:0];
                2'd2:    af_nxt[DATA_W-1:0]     = din;
                default: af_nxt[OFS_W-1:DATA_W] = din[HI_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/ofs_ser_wr.sv
module ofs_ser_wr #(
    parameter int unsigned OFS_W  = 15,
    parameter int unsigned CNT_W  = 5
) (
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             sin,
    input  logic [OFS_W-1:0] ae_cur,
    input  logic [OFS_W-1:0] af_cur,
    output logic [OFS_W-1:0] ae_nxt,
    output logic [OFS_W-1:0] af_nxt,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam int unsigned SER_LEN = 2 * OFS_W;

    // One select per bit: low half of the count hits ae, upper half hits af.
    for (genvar b = 0; b < OFS_W; b++) begin : g_bit
        assign ae_nxt[b] = (en && cnt == CNT_W'(b))         ? sin : ae_cur[b];
        assign af_nxt[b] = (en && cnt == CNT_W'(b + OFS_W)) ? sin : af_cur[b];
    end

    always_comb begin
        cnt_nxt = cnt;
        if (en) begin
            cnt_nxt = (cnt == CNT_W'(SER_LEN - 1)) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ofs_rd_mux.sv
module ofs_rd_mux
    import ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned OFS_W  = 15
) (
    input  logic [PIECE_IDX_W-1:0] idx,
    input  logic [OFS_W-1:0]       ae,
    input  logic [OFS_W-1:0]       af,
    output logic [DATA_W-1:0]      piece
);
    localparam int unsigned HI_W  = OFS_W - DATA_W;
    localparam int unsigned PAD_W = DATA_W - HI_W;

    always_comb begin
        case (idx)
            2'd0:    piece = ae[DATA_W-1:0];
            2'd1:    piece = {{PAD_W{1'b0}}, ae[OFS_W-1:DATA_W]};
            2'd2:    piece = af[DATA_W-1:0];
            default: piece = {{PAD_W{1'b0}}, af[OFS_W-1:DATA_W]};
        endcase
    end
endmodule

// File: rtl/fifo_ofs_regs.sv
module fifo_ofs_regs
    import ofs_pkg::*;
#(
    parameter int unsigned DATA_W   = 9,
    parameter int unsigned OFS_W    = 15,
    parameter int unsigned DEF_NEAR = 127,
    parameter int unsigned DEF_FAR  = 1023
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              ld,
    input  logic              wen,
    input  logic              ren,
    input  logic              sen,
    input  logic              sin,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs,
    output logic              ser_mode
);
    // Requires DATA_W < OFS_W < 2*DATA_W.
    localparam int unsigned SER_LEN = 2 * OFS_W;
    localparam int unsigned CNT_W   = $clog2(SER_LEN);

    typedef struct packed {
        logic [OFS_W-1:0]       ae;
        logic [OFS_W-1:0]       af;
        prog_mode_e             mode;
        logic [PIECE_IDX_W-1:0] widx;
        logic [PIECE_IDX_W-1:0] ridx;
        logic [CNT_W-1:0]       scnt;
        logic [DATA_W-1:0]      dout;
    } ofs_state_t;

    ofs_state_t st_d, st_q;

    logic                   par_en_d, ser_en_d, rd_en_d;
    logic [OFS_W-1:0]       par_ae_d, par_af_d;
    logic [OFS_W-1:0]       ser_ae_d, ser_af_d;
    logic [CNT_W-1:0]       scnt_d;
    logic [DATA_W-1:0]      rd_piece_d;

    assign par_en_d = ld && wen && (st_q.mode == PROG_PAR);
    assign ser_en_d = ld && sen && (st_q.mode == PROG_SER);
    assign rd_en_d  = ld && ren;

    ofs_par_wr #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_par_wr (
        .en     (par_en_d),
        .idx    (st_q.widx),
        .din    (din),
        .ae_cur (st_q.ae),
        .af_cur (st_q.af),
        .ae_nxt (par_ae_d),
        .af_nxt (par_af_d)
    );

    ofs_ser_wr #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_ser_wr (
        .en      (ser_en_d),
        .cnt     (st_q.scnt),
        .sin     (sin),
        .ae_cur  (st_q.ae),
        .af_cur  (st_q.af),
        .ae_nxt  (ser_ae_d),
        .af_nxt  (ser_af_d),
        .cnt_nxt (scnt_d)
    );

    ofs_rd_mux #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd_mux (
        .idx   (st_q.ridx),
        .ae    (st_q.ae),
        .af    (st_q.af),
        .piece (rd_piece_d)
    );

    always_comb begin
        st_d = st_q;
        if (!mrst_n) begin
            // R1 / R8: strap sampled, defaults loaded, all positions restart
            st_d.ae   = ld ? OFS_W'(DEF_FAR) : OFS_W'(DEF_NEAR);
            st_d.af   = ld ? OFS_W'(DEF_FAR) : OFS_W'(DEF_NEAR);
            st_d.mode = ld ? PROG_PAR : PROG_SER;
            st_d.widx = '0;
            st_d.ridx = '0;
            st_d.scnt = '0;
            st_d.dout = '0;
        end else if (!prst_n) begin
            // R7: positions restart, offsets and mode kept
            st_d.widx = '0;
            st_d.ridx = '0;
            st_d.scnt = '0;
        end else begin
            if (par_en_d) begin
                st_d.ae   = par_ae_d;
                st_d.af   = par_af_d;
                st_d.widx = piece_next(st_q.widx);
            end else if (ser_en_d) begin
                st_d.ae   = ser_ae_d;
                st_d.af   = ser_af_d;
                st_d.scnt = scnt_d;
            end
            if (rd_en_d) begin
                st_d.dout = rd_piece_d;
                st_d.ridx = piece_next(st_q.ridx);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout     = st_q.dout;
    assign ae_ofs   = st_q.ae;
    assign af_ofs   = st_q.af;
    assign ser_mode = (st_q.mode == PROG_SER);

endmodule

// File: rtl/fifo_ofs_regs_chk.sv
module fifo_ofs_regs_chk #(
    parameter int unsigned DATA_W   = 9,
    parameter int unsigned OFS_W    = 15,
    parameter int unsigned DEF_NEAR = 127,
    parameter int unsigned DEF_FAR  = 1023
) (
    input logic              clk,
    input logic              mrst_n,
    input logic              prst_n,
    input logic              ld,
    input logic              wen,
    input logic              ren,
    input logic              sen,
    input logic [DATA_W-1:0] dout,
    input logic [OFS_W-1:0]  ae_ofs,
    input logic [OFS_W-1:0]  af_ofs,
    input logic              ser_mode
);
    localparam logic [OFS_W-1:0] NEAR_V = OFS_W'(DEF_NEAR);
    localparam logic [OFS_W-1:0] FAR_V  = OFS_W'(DEF_FAR);

    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!mrst_n)
        $rose(mrst_n) |-> (ae_ofs == ($past(ld) ? FAR_V : NEAR_V)) &&
                          (af_ofs == ($past(ld) ? FAR_V : NEAR_V)) &&
                          (ser_mode == !$past(ld)));

    assert_serial_one_bit_R4: assert property (@(posedge clk) disable iff (!mrst_n)
        (ser_mode && ld && sen && prst_n) |=>
            ($countones({ae_ofs ^ $past(ae_ofs), af_ofs ^ $past(af_ofs)}) <= 1));

    assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!mrst_n)
        !(ld && ren) |=> $stable(dout));

    assert_no_ld_no_write_R6: assert property (@(posedge clk) disable iff (!mrst_n)
        !ld |=> ($stable(ae_ofs) && $stable(af_ofs)));

    assert_par_ignores_serial_R6: assert property (@(posedge clk) disable iff (!mrst_n)
        (!ser_mode && !wen) |=> ($stable(ae_ofs) && $stable(af_ofs)));

    assert_prst_keeps_R7: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(ser_mode)));

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(ser_mode));

endmodule

bind fifo_ofs_regs fifo_ofs_regs_chk #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .DEF_NEAR(DEF_NEAR), .DEF_FAR(DEF_FAR)
) u_chk (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .wen(wen),
    .ren(ren), .sen(sen), .dout(dout), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .ser_mode(ser_mode)
);

// File: tb/fifo_ofs_regs_bench.sv
module fifo_ofs_regs_bench;
    logic       clk = 1'b0;
    logic       mrst_n = 1'b0, prst_n = 1'b1, ld = 1'b1;
    logic       wen = 1'b0, ren = 1'b0, sen = 1'b0, sin = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic [14:0] ae_ofs, af_ofs;
    logic       ser_mode;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    fifo_ofs_regs u_fifo_ofs_regs (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .wen(wen),
        .ren(ren), .sen(sen), .sin(sin), .din(din), .dout(dout),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ser_mode(ser_mode)
    );

    // {wr, rd, din[8:0], exp_dout[8:0]}; ae=0x5ABC, af=0x2345
    localparam int NV = 9;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 1'b0, 9'h0BC, 9'h000},
        {1'b1, 1'b0, 9'h02D, 9'h000},
        {1'b1, 1'b0, 9'h145, 9'h000},
        {1'b1, 1'b0, 9'h011, 9'h000},
        {1'b0, 1'b1, 9'h000, 9'h0BC},
        {1'b0, 1'b1, 9'h000, 9'h02D},
        {1'b0, 1'b1, 9'h000, 9'h145},
        {1'b0, 1'b1, 9'h000, 9'h011},
        {1'b0, 1'b1, 9'h000, 9'h0BC}
    };

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, let one posedge pass, return at next negedge.
    task automatic cyc(input logic mr, input logic pr, input logic l, input logic w,
                       input logic r, input logic s, input logic si, input logic [8:0] d);
        mrst_n = mr; prst_n = pr; ld = l; wen = w; ren = r; sen = s; sin = si; din = d;
        @(posedge clk);
        @(negedge clk);
        mrst_n = 1'b1; prst_n = 1'b1; wen = 1'b0; ren = 1'b0; sen = 1'b0;
    endtask

    task automatic mreset(input logic l);
        cyc(1'b0, 1'b1, l, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0);
    endtask

    task automatic ser_load(input logic [14:0] a, input logic [14:0] f);
        for (int i = 0; i < 30; i++)
            cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, (i < 15) ? a[i] : f[i-15], 9'h0);
    endtask

    task automatic rd_piece(input string req, input logic [8:0] exp);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9'h0);
        chk(req, 32'(dout), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        @(negedge clk);
        // R1: strap high
        mreset(1'b1);
        chk("R1 ae default 1023", 32'(ae_ofs), 32'd1023);
        chk("R1 af default 1023", 32'(af_ofs), 32'd1023);
        chk("R1 parallel mode", 32'(ser_mode), 32'd0);
        chk("R1 dout cleared", 32'(dout), 32'd0);

        // R2 / R5: table of parallel writes and reads
        for (int i = 0; i < NV; i++) begin
            cyc(1'b1, 1'b1, 1'b1, VEC[i][19], VEC[i][18], 1'b0, 1'b0, VEC[i][17:9]);
            if (VEC[i][18]) chk("R5 readback piece", 32'(dout), 32'(VEC[i][8:0]));
        end
        chk("R2 ae after writes", 32'(ae_ofs), 32'h5ABC);
        chk("R2 af after writes", 32'(af_ofs), 32'h2345);

        // R3: fifth write wraps to ae low piece
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h1FF);
        chk("R3 wrap ae", 32'(ae_ofs), 32'h5BFF);
        chk("R3 wrap af untouched", 32'(af_ofs), 32'h2345);

        // R6: serial strobe in parallel mode, write without ld
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0);
        chk("R6 sen in parallel mode", 32'(ae_ofs), 32'h5BFF);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000);
        chk("R6 wen without ld ae", 32'(ae_ofs), 32'h5BFF);
        chk("R6 wen without ld af", 32'(af_ofs), 32'h2345);
        chk("R5 dout held without ld", 32'(dout), 32'h0BC);

        // R7: partial reset keeps values, restarts indices
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9'h0AA);
        chk("R7 ae kept", 32'(ae_ofs), 32'h5BFF);
        chk("R7 af kept", 32'(af_ofs), 32'h2345);
        chk("R7 mode kept", 32'(ser_mode), 32'd0);
        // write index now at 1 (after the wrap write), so restart lands on ae low
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h001);
        chk("R7 write index restarted", 32'(ae_ofs), 32'h5A01);
        rd_piece("R7 read index restarted", 9'h001);

        // R1 / R9: strap low
        mreset(1'b0);
        chk("R1 ae default 127", 32'(ae_ofs), 32'd127);
        chk("R1 af default 127", 32'(af_ofs), 32'd127);
        chk("R1 serial mode", 32'(ser_mode), 32'd1);

        // R4: full serial pass
        ser_load(15'h1357, 15'h7A5C);
        chk("R4 serial ae", 32'(ae_ofs), 32'h1357);
        chk("R4 serial af", 32'(af_ofs), 32'h7A5C);
        chk("R9 mode held", 32'(ser_mode), 32'd1);

        // R6: parallel write in serial mode ignored
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
        chk("R6 wen in serial mode", 32'(ae_ofs), 32'h1357);

        // R5: readback in serial mode (0x1357 -> 0x157/0x009; 0x7A5C -> 0x05C/0x03D)
        rd_piece("R5 serial-mode read 0", 9'h157);
        rd_piece("R5 serial-mode read 1", 9'h009);
        rd_piece("R5 serial-mode read 2", 9'h05C);
        rd_piece("R5 serial-mode read 3", 9'h03D);

        // R4: count wraps after 30 bits, next bit hits ae[0]
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h0);
        chk("R4 serial wrap", 32'(ae_ofs), 32'h1356);

        // R8: partial serial pass, master reset, then a clean pass
        for (int i = 0; i < 5; i++)
            cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0);
        mreset(1'b0);
        ser_load(15'h0F0F, 15'h4321);
        chk("R8 counter restarted ae", 32'(ae_ofs), 32'h0F0F);
        chk("R8 counter restarted af", 32'(af_ofs), 32'h4321);

        report();
    end
endmodule